// File: doc/BRIEF.md
# Shift Register with Parallel Load

This block is a small register that can take a new value in two ways. It can shift its contents up by one stage and take a fresh bit from a serial input into the lowest stage. It can also capture a whole word from a parallel input. When neither control is active it keeps its value. A datapath uses it to turn a serial bit stream into a word, to preload a word, or to hold a value between operations.

Each stage has one three-way selector in front of its flip-flop. The selector picks the stage below it (or the serial input, for stage 0), the matching parallel input bit, or the stage's own output. Shift takes priority over load. The top stage drives a serial output, so that output always shows the bit that the next shift will push out. An asynchronous active-low reset clears every stage.

Top module: `shreg_pload`

## Requirements
- R1: While `rst_ni` is low, `q_o` is all zeros. The clear takes effect at once, without waiting for a clock edge.
- R2: When `shift_i` is 1 at a rising edge, stage 0 takes `ser_i` and each stage i > 0 takes the old value of stage i-1. That is, the next `q_o` equals `{q_o[WIDTH-2:0], ser_i}`.
- R3: When `shift_i` and `load_i` are both 1, the shift of R2 happens and `par_i` has no effect on `q_o`.
- R4: When `shift_i` is 0 and `load_i` is 1 at a rising edge, `q_o` takes `par_i`, with bit i going to stage i.
- R5: When `shift_i` and `load_i` are both 0 at a rising edge, `q_o` keeps its value whatever `ser_i` and `par_i` carry.
- R6: `ser_o` always equals the top stage, `q_o[WIDTH-1]`.
- R7: After reset, WIDTH consecutive shifts fill the register with the bits presented on `ser_i`. The first bit lands in `q_o[WIDTH-1]` and the last bit lands in `q_o[0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all updates happen on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| shift_i | input | 1 | Shift up by one stage (takes priority over load) |
| load_i | input | 1 | Parallel load when shift is low |
| ser_i | input | 1 | Serial bit entering stage 0 |
| par_i | input | WIDTH | Parallel load word |
| q_o | output | WIDTH | Register contents |
| ser_o | output | 1 | Top stage, the next bit to leave on a shift |

## Verification
The hardest case to reach from the ports is a conflict between the controls on a register that already holds a known, arbitrary value. Examples are both controls high while `par_i` differs from the shifted result, or a hold while the data inputs are changing. To reach it, the stimulus first preloads every one of the 16 possible register values. From each preloaded value it applies every combination of the two controls, the serial bit and the parallel word, then checks the result against an arithmetic model. Separate sequences check the serial fill from reset and a reset asserted between clock edges.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } op_e;
endpackage

// File: rtl/shreg_ctrl.sv
module shreg_ctrl
  import shreg_pkg::*;
(
  input  logic shift_i,
  input  logic load_i,
  output op_e  op_o
);
  // shift wins over load
  always_comb begin
    if (shift_i)     op_o = OP_SHIFT;
    else if (load_i) op_o = OP_LOAD;
    else             op_o = OP_HOLD;
  end
endmodule

// File: rtl/shreg_cell.sv
module shreg_cell
  import shreg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  op_e  op_i,
  input  logic shin_i,
  input  logic par_i,
  output logic q_o
);
  logic d;

  always_comb begin
    unique case (op_i)
      OP_SHIFT: d = shin_i;
      OP_LOAD:  d = par_i;
      default:  d = q_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d;
  end
endmodule

// File: rtl/shreg_pload.sv
module shreg_pload
  import shreg_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             load_i,
  input  logic             ser_i,
  input  logic [WIDTH-1:0] par_i,
  output logic [WIDTH-1:0] q_o,
  output logic             ser_o
);
  localparam int TOP = WIDTH - 1;

  op_e        op;
  logic [TOP:0] shin;

  shreg_ctrl u_ctrl (
    .shift_i (shift_i),
    .load_i  (load_i),
    .op_o    (op)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign shin[i] = ser_i;
    end else begin : g_rest
      assign shin[i] = q_o[i-1];
    end
    shreg_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .op_i   (op),
      .shin_i (shin[i]),
      .par_i  (par_i[i]),
      .q_o    (q_o[i])
    );
  end

  assign ser_o = q_o[TOP];
endmodule

// File: rtl/shreg_pload_chk.sv
module shreg_pload_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             shift_i,
  input logic             load_i,
  input logic             ser_i,
  input logic [WIDTH-1:0] par_i,
  input logic [WIDTH-1:0] q_o
);
  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> q_o == '0); // R1

  AST_SHIFT_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> q_o == {$past(q_o[WIDTH-2:0]), $past(ser_i)}); // R2

  AST_SHIFT_OVER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && load_i && (par_i != {q_o[WIDTH-2:0], ser_i}))
      |=> q_o != $past(par_i)); // R3

  AST_LOAD_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && load_i) |=> q_o == $past(par_i)); // R4

  AST_HOLD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && !load_i) |=> $stable(q_o)); // R5
endmodule

bind shreg_pload shreg_pload_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .shift_i (shift_i),
  .load_i  (load_i),
  .ser_i   (ser_i),
  .par_i   (par_i),
  .q_o     (q_o)
);

// File: tb/shreg_pload_tb.sv
module shreg_pload_tb;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         shift = 1'b0;
  logic         load = 1'b0;
  logic         ser = 1'b0;
  logic [W-1:0] par = '0;
  logic [W-1:0] q;
  logic         so;

  int total = 0;
  int bad = 0;
  logic [W-1:0] model = '0;

  always #4 clk = ~clk;

  shreg_pload #(.WIDTH(W)) u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .shift_i (shift),
    .load_i  (load),
    .ser_i   (ser),
    .par_i   (par),
    .q_o     (q),
    .ser_o   (so)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic sh, input logic ld, input logic si, input logic [W-1:0] pd);
    string tag;
    @(negedge clk);
    shift = sh; load = ld; ser = si; par = pd;
    if (sh) model = {model[W-2:0], si};
    else if (ld) model = pd;
    if (sh && ld) tag = "R3";
    else if (sh) tag = "R2";
    else if (ld) tag = "R4";
    else tag = "R5";
    @(posedge clk);
    #1;
    check(tag, q, model);
    check("R6", {{(W-1){1'b0}}, so}, {{(W-1){1'b0}}, model[W-1]});
  endtask

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    check("R1", q, '0);
    #20;
    @(negedge clk);
    rst_n = 1'b1;

    // R7: serial fill from reset, first bit ends at the top
    model = '0;
    step(1'b1, 1'b0, 1'b1, 4'h0);
    step(1'b1, 1'b0, 1'b0, 4'hF);
    step(1'b1, 1'b0, 1'b1, 4'h0);
    step(1'b1, 1'b0, 1'b1, 4'h0);
    check("R7", q, 4'b1011);

    // Exhaustive: every start state x every control/data combination
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c < 8; c++) begin
        for (int p = 0; p < 16; p++) begin
          step(1'b0, 1'b1, 1'b0, 4'(s));
          step(c[2], c[1], c[0], 4'(p));
        end
      end
    end

    // R1: reset between edges clears without a clock edge
    step(1'b0, 1'b1, 1'b0, 4'hA);
    @(negedge clk);
    shift = 1'b0; load = 1'b0;
    #1;
    rst_n = 1'b0;
    #1;
    check("R1", q, '0);
    @(posedge clk);
    #1;
    check("R1", q, '0);
    @(negedge clk);
    rst_n = 1'b1;
    model = '0;
    step(1'b0, 1'b0, 1'b1, 4'hF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule